// File: doc/BRIEF.md
# Packet DMA Channel Control with Teardown

This block holds the control words of a packet DMA with several channels. Each channel has one control word for transmit and one for receive. A register port reads and writes these words and one further word. That word names the free queue that supplies teardown descriptors. The enable bits of the control words drive per-channel enable outputs toward the data engine, which sits outside this block.

Software can ask for a teardown on an enabled channel. Once that channel's data engine reports it idle, the block pops one descriptor address from the teardown free queue. It marks that descriptor as a teardown record for the channel and direction. It offers the record to the channel's completion queue through a push handshake. When the push is accepted, the block clears both the enable bit and the teardown bit of that control word.

Pending teardowns are served one at a time, in a fixed priority order. The queue manager that answers the pop and push requests is external to the block.

Top module: `dma_chctl`

## Requirements
- R1: After reset every control word and the teardown-source word read 0, all enables are low, and neither pop_req_o nor push_req_o is asserted.
- R2: The transmit control word of channel n is at byte offset 0x800 + 0x20*n and the receive word at 0x808 + 0x20*n; bit 31 of each is the enable, shown on tx_en_o[n] / rx_en_o[n]; unmapped offsets read 0.
- R3: A receive word keeps bit 24 (retry on starvation), bit 14 (host descriptor type) and bits 11:0 (completion queue); a transmit word keeps bits 31, 30 and 11:0 only; all other bits read 0.
- R4: The word at offset 0x004 keeps bits 11:0 as the teardown free-queue number; pop_qid_o always shows it.
- R5: Writing bit 30 = 1 to an enabled, idle channel word sets bit 30 in readback; pop_req_o rises two cycles after the write cycle and the other fields are unchanged.
- R6: A write with bit 30 = 1 to a word whose enable is 0 has no effect: readback stays unchanged and no pop is requested.
- R7: While the busy input of the slot (tx_busy_i[n] or rx_busy_i[n]) is high, its pending teardown does not start; it starts the cycle after busy falls.
- R8: pop_req_o stays high while pop_ack_i is low (empty free queue) and the pop completes in the first cycle in which pop_ack_i is high; push_req_o rises on the next cycle.
- R9: The pushed record word has 0x13 in bits 31:27, bit 16 = 1 for a receive channel, bits 4:0 = channel number and all other bits 0; push_desc_o is the popped address and push_qid_o is that word's completion queue.
- R10: push_req_o is held with a stable descriptor until push_ack_i; one cycle after acceptance bits 31 and 30 of that word read 0 together, while the other fields are kept.
- R11: Any write to a word whose bit 30 is set is ignored.
- R12: Pending teardowns are served one at a time, lowest slot first, where slot = 2*n + (1 for receive, 0 for transmit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| tx_busy_i | input | NUM_CH | Transmit engine of channel n is mid-packet |
| rx_busy_i | input | NUM_CH | Receive engine of channel n is mid-packet |
| tx_en_o | output | NUM_CH | Transmit enable per channel |
| rx_en_o | output | NUM_CH | Receive enable per channel |
| pop_req_o | output | 1 | Pop request to the teardown free queue |
| pop_qid_o | output | QID_W | Queue to pop from |
| pop_ack_i | input | 1 | Pop served this cycle (queue not empty) |
| pop_desc_i | input | DESC_W | Popped descriptor address |
| push_req_o | output | 1 | Push request of a teardown record |
| push_qid_o | output | QID_W | Completion queue to push to |
| push_desc_o | output | DESC_W | Descriptor address being pushed |
| push_word_o | output | 32 | Teardown record first word |
| push_ack_i | input | 1 | Push accepted this cycle |

## Verification
Register readback is combinational, so a written value is due at the first sample after the write edge. A teardown request shows on pop_req_o two cycles after the write cycle: one cycle to register bit 30 and one to select the slot. The push follows one cycle after the accepted pop, and the cleared enable follows one cycle after the accepted push. The bench model advances its registers, selection and queue phases on the same edges as the design and takes all inputs from the stimulus it drives. Every output is compared at the falling edge, halfway between the edge at which the inputs were taken and the next one, so each result is checked in the exact cycle it becomes due.

// File: rtl/dmactl_pkg.sv
package dmactl_pkg;

  localparam int BIT_EN    = 31;
  localparam int BIT_TD    = 30;
  localparam int BIT_RETRY = 24;
  localparam int BIT_HOST  = 14;
  localparam int BIT_DIR   = 16;
  localparam logic [4:0] TD_TYPE = 5'h13;
  localparam int CTRL_BASE = 32'h800;
  localparam int CH_STRIDE = 32'h20;
  localparam int RX_OFS    = 32'h8;
  localparam int TDQ_OFS   = 32'h4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_POP,
    ST_PUSH
  } td_state_e;

  function automatic logic [31:0] td_word(input logic is_rx, input int unsigned ch);
    logic [31:0] w;
    w = '0;
    w[31:27] = TD_TYPE;
    w[BIT_DIR] = is_rx;
    w[4:0] = ch[4:0];
    return w;
  endfunction

endpackage

// File: rtl/dmactl_regs.sv
module dmactl_regs #(
  parameter int NUM_CH = 4,
  parameter int QID_W  = 12,
  parameter int AW     = 12,
  localparam int NSLOT = 2 * NUM_CH,
  localparam int SW    = $clog2(NSLOT)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [AW-1:0]                 addr_i,
  input  logic [31:0]                   wdata_i,
  output logic [31:0]                   rdata_o,
  input  logic                          clr_i,
  input  logic [SW-1:0]                 clr_slot_i,
  output logic [NSLOT-1:0]              en_o,
  output logic [NSLOT-1:0]              td_o,
  output logic [NSLOT-1:0][QID_W-1:0]   cq_o,
  output logic [QID_W-1:0]              tdq_o
);
  import dmactl_pkg::*;

  localparam logic [AW-1:0] TDQ_ADDR = AW'(TDQ_OFS);

  logic [NSLOT-1:0][31:0] rd_slot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tdq_o <= '0;
    else if (we_i && addr_i == TDQ_ADDR) tdq_o <= wdata_i[QID_W-1:0];
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam logic [AW-1:0] BASE = AW'(CTRL_BASE + CH_STRIDE * (s / 2) + RX_OFS * (s % 2));
    localparam bit IS_RX = (s % 2) == 1;

    logic hit, wr, retry_q, host_q;
    assign hit = addr_i == BASE;
    assign wr  = we_i && hit && !td_o[s];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_o[s] <= 1'b0;
        td_o[s] <= 1'b0;
        cq_o[s] <= '0;
      end else if (clr_i && clr_slot_i == SW'(s)) begin
        en_o[s] <= 1'b0;
        td_o[s] <= 1'b0;
      end else if (wr) begin
        if (wdata_i[BIT_TD]) begin
          if (en_o[s]) td_o[s] <= 1'b1;
        end else begin
          en_o[s] <= wdata_i[BIT_EN];
          cq_o[s] <= wdata_i[QID_W-1:0];
        end
      end
    end

    if (IS_RX) begin : g_rx
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          retry_q <= 1'b0;
          host_q  <= 1'b0;
        end else if (wr && !wdata_i[BIT_TD]) begin
          retry_q <= wdata_i[BIT_RETRY];
          host_q  <= wdata_i[BIT_HOST];
        end
      end
    end else begin : g_tx
      assign retry_q = 1'b0;
      assign host_q  = 1'b0;
    end

    always_comb begin
      rd_slot[s] = '0;
      if (hit) begin
        rd_slot[s][BIT_EN]      = en_o[s];
        rd_slot[s][BIT_TD]      = td_o[s];
        rd_slot[s][BIT_RETRY]   = retry_q;
        rd_slot[s][BIT_HOST]    = host_q;
        rd_slot[s][QID_W-1:0]   = cq_o[s];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == TDQ_ADDR) rdata_o[QID_W-1:0] = tdq_o;
    for (int s = 0; s < NSLOT; s++) rdata_o = rdata_o | rd_slot[s];
  end

endmodule

// File: rtl/dmactl_arb.sv
module dmactl_arb #(
  parameter int N = 8,
  localparam int SW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          vld_o,
  output logic [SW-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    vld_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = SW'(i);
    end
  end
endmodule

// File: rtl/dmactl_td_fsm.sv
module dmactl_td_fsm #(
  parameter int NSLOT  = 8,
  parameter int DESC_W = 32,
  localparam int SW = $clog2(NSLOT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gnt_vld_i,
  input  logic [SW-1:0]     gnt_idx_i,
  input  logic              pop_ack_i,
  input  logic [DESC_W-1:0] pop_desc_i,
  input  logic              push_ack_i,
  output logic              idle_o,
  output logic              pop_req_o,
  output logic              push_req_o,
  output logic              clr_o,
  output logic [SW-1:0]     slot_o,
  output logic [DESC_W-1:0] desc_o
);
  import dmactl_pkg::*;

  td_state_e state_q;

  assign idle_o     = state_q == ST_IDLE;
  assign pop_req_o  = state_q == ST_POP;
  assign push_req_o = state_q == ST_PUSH;
  assign clr_o      = push_req_o && push_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      slot_o  <= '0;
      desc_o  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (gnt_vld_i) begin
          slot_o  <= gnt_idx_i;
          state_q <= ST_POP;
        end
        ST_POP: if (pop_ack_i) begin
          desc_o  <= pop_desc_i;
          state_q <= ST_PUSH;
        end
        ST_PUSH: if (push_ack_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_chctl.sv
module dma_chctl #(
  parameter int NUM_CH = 4,
  parameter int QID_W  = 12,
  parameter int DESC_W = 32,
  parameter int AW     = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [NUM_CH-1:0] tx_busy_i,
  input  logic [NUM_CH-1:0] rx_busy_i,
  output logic [NUM_CH-1:0] tx_en_o,
  output logic [NUM_CH-1:0] rx_en_o,
  output logic              pop_req_o,
  output logic [QID_W-1:0]  pop_qid_o,
  input  logic              pop_ack_i,
  input  logic [DESC_W-1:0] pop_desc_i,
  output logic              push_req_o,
  output logic [QID_W-1:0]  push_qid_o,
  output logic [DESC_W-1:0] push_desc_o,
  output logic [31:0]       push_word_o,
  input  logic              push_ack_i
);
  import dmactl_pkg::*;

  localparam int NSLOT = 2 * NUM_CH;
  localparam int SW    = $clog2(NSLOT);

  logic [NSLOT-1:0]            en, td, busy, elig;
  logic [NSLOT-1:0][QID_W-1:0] cq;
  logic                        gnt_vld, idle, clr;
  logic [SW-1:0]               gnt_idx, slot;

  dmactl_regs #(.NUM_CH(NUM_CH), .QID_W(QID_W), .AW(AW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .clr_i      (clr),
    .clr_slot_i (slot),
    .en_o       (en),
    .td_o       (td),
    .cq_o       (cq),
    .tdq_o      (pop_qid_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign busy[2*c]   = tx_busy_i[c];
    assign busy[2*c+1] = rx_busy_i[c];
    assign tx_en_o[c]  = en[2*c];
    assign rx_en_o[c]  = en[2*c+1];
  end

  assign elig = td & ~busy & {NSLOT{idle}};

  dmactl_arb #(.N(NSLOT)) u_arb (
    .req_i (elig),
    .vld_o (gnt_vld),
    .idx_o (gnt_idx)
  );

  dmactl_td_fsm #(.NSLOT(NSLOT), .DESC_W(DESC_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .gnt_vld_i  (gnt_vld),
    .gnt_idx_i  (gnt_idx),
    .pop_ack_i  (pop_ack_i),
    .pop_desc_i (pop_desc_i),
    .push_ack_i (push_ack_i),
    .idle_o     (idle),
    .pop_req_o  (pop_req_o),
    .push_req_o (push_req_o),
    .clr_o      (clr),
    .slot_o     (slot),
    .desc_o     (push_desc_o)
  );

  assign push_qid_o  = cq[slot];
  assign push_word_o = td_word(slot[0], 32'(slot) >> 1);

endmodule

// File: rtl/dma_chctl_chk.sv
module dma_chctl_chk #(
  parameter int QID_W  = 12,
  parameter int DESC_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pop_req_o,
  input logic              pop_ack_i,
  input logic              push_req_o,
  input logic              push_ack_i,
  input logic [DESC_W-1:0] push_desc_o,
  input logic [31:0]       push_word_o
);
  a_r8_pop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_req_o && !pop_ack_i |=> pop_req_o);

  a_r8_push_follows_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_req_o && pop_ack_i |=> push_req_o);

  a_r9_record_type: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_req_o |-> push_word_o[31:27] == 5'h13);

  a_r10_push_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_req_o && !push_ack_i |=> push_req_o && $stable(push_desc_o));

  a_r10_push_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_req_o && push_ack_i |=> !push_req_o);

  a_r12_one_at_a_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pop_req_o && push_req_o));
endmodule

bind dma_chctl dma_chctl_chk #(.QID_W(QID_W), .DESC_W(DESC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pop_req_o   (pop_req_o),
  .pop_ack_i   (pop_ack_i),
  .push_req_o  (push_req_o),
  .push_ack_i  (push_ack_i),
  .push_desc_o (push_desc_o),
  .push_word_o (push_word_o)
);

// File: tb/test_dma_chctl.sv
module test_dma_chctl;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 4;
  localparam int NSLOT  = 2 * NUM_CH;
  localparam int QID_W  = 12;
  localparam int DESC_W = 32;
  localparam int AW     = 12;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              reg_we_i = 1'b0;
  logic [AW-1:0]     reg_addr_i = '0;
  logic [31:0]       reg_wdata_i = '0;
  logic [31:0]       reg_rdata_o;
  logic [NUM_CH-1:0] tx_busy_i = '0;
  logic [NUM_CH-1:0] rx_busy_i = '0;
  logic [NUM_CH-1:0] tx_en_o, rx_en_o;
  logic              pop_req_o;
  logic [QID_W-1:0]  pop_qid_o;
  logic              pop_ack_i = 1'b0;
  logic [DESC_W-1:0] pop_desc_i = '0;
  logic              push_req_o;
  logic [QID_W-1:0]  push_qid_o;
  logic [DESC_W-1:0] push_desc_o;
  logic [31:0]       push_word_o;
  logic              push_ack_i = 1'b0;

  dma_chctl #(.NUM_CH(NUM_CH), .QID_W(QID_W), .DESC_W(DESC_W), .AW(AW)) i_dma_chctl (.*);

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  // reference model state
  bit        m_en[NSLOT], m_td[NSLOT], m_rt[NSLOT], m_hs[NSLOT];
  int        m_cq[NSLOT];
  int        m_tdq = 0;
  int        m_phase = 0;  // 0 idle, 1 pop, 2 push
  int        m_sel = 0;
  logic [31:0] m_desc = '0;
  logic [31:0] fq[$];
  bit        add_req = 1'b0;
  logic [31:0] add_val = '0;

  int    n_checks = 0;
  int    n_fails = 0;
  string cur_tag = "R1";
  bit    finished = 1'b0;

  function automatic int slot_addr(int s);
    return 'h800 + 'h20 * (s / 2) + 8 * (s % 2);
  endfunction

  function automatic logic [31:0] exp_rd(int a);
    logic [31:0] w;
    w = '0;
    if (a == 4) w[11:0] = m_tdq[11:0];
    for (int s = 0; s < NSLOT; s++) begin
      if (a == slot_addr(s)) begin
        w[31] = m_en[s];
        w[30] = m_td[s];
        w[24] = m_rt[s];
        w[14] = m_hs[s];
        w[11:0] = m_cq[s][11:0];
      end
    end
    return w;
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int s = 0; s < NSLOT; s++) begin
        m_en[s] = 0; m_td[s] = 0; m_rt[s] = 0; m_hs[s] = 0; m_cq[s] = 0;
      end
      m_tdq = 0; m_phase = 0; m_sel = 0; m_desc = '0;
    end else begin
      if (m_phase == 2) begin
        if (push_ack_i) begin
          m_en[m_sel] = 0; m_td[m_sel] = 0; m_phase = 0;
        end
      end else if (m_phase == 1) begin
        if (fq.size() != 0) begin
          m_desc = fq.pop_front();
          m_phase = 2;
        end
      end else begin
        for (int s = NSLOT - 1; s >= 0; s--) begin
          bit b;
          b = (s % 2) ? rx_busy_i[s/2] : tx_busy_i[s/2];
          if (m_td[s] && !b) begin
            m_sel = s; m_phase = 1;
          end
        end
      end
      if (reg_we_i) begin
        if (int'(reg_addr_i) == 4) m_tdq = int'(reg_wdata_i[11:0]);
        for (int s = 0; s < NSLOT; s++) begin
          if (int'(reg_addr_i) == slot_addr(s) && !m_td[s]) begin
            if (reg_wdata_i[30]) begin
              if (m_en[s]) m_td[s] = 1;
            end else begin
              m_en[s] = reg_wdata_i[31];
              m_cq[s] = int'(reg_wdata_i[11:0]);
              if (s % 2 == 1) begin
                m_rt[s] = reg_wdata_i[24];
                m_hs[s] = reg_wdata_i[14];
              end
            end
          end
        end
      end
    end
    if (add_req) fq.push_back(add_val);
    pop_ack_i  <= fq.size() != 0;
    pop_desc_i <= (fq.size() != 0) ? fq[0] : '0;
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s act=%h exp=%h", cur_tag, what, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      logic [31:0] w;
      chk("rdata", reg_rdata_o, exp_rd(int'(reg_addr_i)));
      chk("pop_qid", 32'(pop_qid_o), 32'(m_tdq[11:0]));
      chk("pop_req", 32'(pop_req_o), 32'(m_phase == 1));
      chk("push_req", 32'(push_req_o), 32'(m_phase == 2));
      for (int c = 0; c < NUM_CH; c++) begin
        chk("tx_en", 32'(tx_en_o[c]), 32'(m_en[2*c]));
        chk("rx_en", 32'(rx_en_o[c]), 32'(m_en[2*c+1]));
      end
      if (m_phase == 2) begin
        w = '0;
        w[31:27] = 5'h13;
        w[16] = m_sel[0];
        w[4:0] = 5'(m_sel / 2);
        chk("push_word", push_word_o, w);
        chk("push_desc", push_desc_o, m_desc);
        chk("push_qid", 32'(push_qid_o), 32'(m_cq[m_sel][11:0]));
      end
    end
  end

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk_i);
      #1;
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    reg_we_i = 1'b1;
    reg_addr_i = AW'(a);
    reg_wdata_i = d;
    step(1);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(int a);
    reg_addr_i = AW'(a);
    step(1);
  endtask

  task automatic add_desc(logic [31:0] d);
    add_req = 1'b1;
    add_val = d;
    step(1);
    add_req = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); #1;
    rst_ni = 1'b1;
    cur_tag = "R1";
    rd('h800); rd('h808); rd('h004); step(1);

    cur_tag = "R4";
    wr('h004, 32'hFFFF_FABC);
    rd('h004);

    cur_tag = "R2";
    wr('h800, 32'h8000_0011);
    wr('h808, 32'h8000_0055);
    wr('h860, 32'h8000_0033);
    rd('h800); rd('h808); rd('h804); rd('h810);

    cur_tag = "R3";
    wr('h820, 32'h8100_4FFF);
    wr('h848, 32'h8100_C123);
    wr('h868, 32'h8100_0077);
    rd('h820); rd('h848); rd('h868);

    cur_tag = "R6";
    wr('h828, 32'h4000_0000);
    rd('h828); step(3);

    cur_tag = "R5";
    push_ack_i = 1'b1;
    add_desc(32'h1000_0040);
    wr('h820, 32'h4000_0000);
    rd('h820); step(2);
    cur_tag = "R9";
    step(2);
    cur_tag = "R10";
    rd('h820); step(2);

    cur_tag = "R8";
    wr('h848, 32'h4000_0000);
    rd('h848); step(5);
    add_desc(32'h2000_0080);
    step(5);

    cur_tag = "R7";
    rx_busy_i[0] = 1'b1;
    add_desc(32'h3000_00C0);
    wr('h808, 32'h4000_0000);
    rd('h808); step(5);
    rx_busy_i[0] = 1'b0;
    step(5);

    cur_tag = "R11";
    push_ack_i = 1'b0;
    add_desc(32'h4000_0100);
    wr('h860, 32'h4000_0000);
    step(3);
    wr('h860, 32'h8000_0999);
    rd('h860); step(2);
    cur_tag = "R10";
    push_ack_i = 1'b1;
    rd('h860); step(3);

    cur_tag = "R12";
    wr('h860, 32'h8000_0033);
    add_desc(32'h5000_0140);
    add_desc(32'h6000_0180);
    tx_busy_i[0] = 1'b1;
    rx_busy_i[3] = 1'b1;
    wr('h868, 32'h4000_0000);
    wr('h800, 32'h4000_0000);
    step(2);
    tx_busy_i[0] = 1'b0;
    rx_busy_i[3] = 1'b0;
    rd('h800); step(4);
    rd('h868); step(6);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      n_fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
    end
  end
endmodule